// File: doc/BRIEF.md
# DMA Destination Address and Byte Counter

This block is the write-side datapath of a single DMA channel. It holds the address where the next operand will be written and the number of bytes still owed in the current block. Software loads both through a simple write port. The bus sequencer reads the address, runs one write, and then signals how it ended.

A clean completion moves the address forward by the operand size, if stepping is enabled, and takes the same amount off the count. A bus error freezes both registers, so the address still names the operand that failed. A misaligned address for a word or long-word operand blocks all transfers and raises a configuration error.

The block tells the sequencer on every cycle whether another operand may start. It flags when the block is finished. A stop input freezes the whole datapath.

Top module: `dma_dst_path`

## Requirements
- R1: While `stop` is 0, a pulse on `wr_addr` or `wr_count` loads `wdata` into the address or counter register. The new value appears on `dst_addr` or `byte_cnt` after the next clock edge.
- R2: `op_size` selects the operand size and its step: 00 is byte (step 1), 01 is word (step 2), and 10 or 11 is long word (step 4).
  - When `done` is high, `xfer_ok` is high, `bus_err` is low and no register write is pending, the operand is accepted.
  - With `inc_en` = 1, an accepted operand moves `dst_addr` up by the step after the next edge.
- R3: With `inc_en` = 0, an accepted operand leaves `dst_addr` unchanged. The counter still moves.
- R4: The address uses unsigned 32-bit arithmetic and wraps, so FFFFFFFF plus 1 gives 00000000.
- R5: When `op_size` is not byte and `dst_addr` bit 0 is 1:
  - `xfer_ok` is 0 in the same cycle.
  - `cfg_err` is 1 after the next edge.
  - `done` pulses have no effect.
- R6: An accepted operand lowers `byte_cnt` by the step. `xfer_ok` is 0 while `byte_cnt` is smaller than the step.
- R7: While `byte_cnt` is 0, `blk_done` is 1 and `xfer_ok` is 0.
- R8: A `bus_err` pulse while `stop` is 0 has three effects:
  - both registers stay unchanged, even if `done` is high in the same cycle;
  - `berr_flag` is set and stays set;
  - `xfer_ok` stays 0 until a register write.
- R9: A register write takes priority over a `done` pulse in the same cycle, and no address or count step happens in that cycle. A register write also clears `cfg_err` and `berr_flag`.
- R10: While `stop` is 1:
  - register writes, `done` and `bus_err` are ignored;
  - `xfer_ok` is 0.
- R11: Reset clears `cfg_err` and `berr_flag` and leaves `dst_addr` and `byte_cnt` at their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the flags only |
| wr_addr | input | 1 | Load `wdata` into the address register |
| wr_count | input | 1 | Load `wdata` into the byte counter |
| wdata | input | 32 | Register write data |
| inc_en | input | 1 | Step the address after each accepted operand |
| op_size | input | 2 | Operand size: 00 byte, 01 word, 1x long word |
| stop | input | 1 | Module stop; freezes the datapath |
| done | input | 1 | Current operand's write has finished |
| bus_err | input | 1 | Current operand ended with a bus error |
| dst_addr | output | 32 | Next destination address; the register read value |
| byte_cnt | output | 32 | Bytes left in the block; the register read value |
| cfg_err | output | 1 | Misalignment configuration error |
| xfer_ok | output | 1 | Another operand may start |
| blk_done | output | 1 | Byte count has reached zero |
| berr_flag | output | 1 | Sticky bus-error indicator |

## Verification
Some behaviours are checked by assertions on every clock edge:
- the address step after each accepted operand;
- the frozen registers after a bus error or while stopped;
- the permit being blocked by misalignment or a zero count;
- the bus-error flag staying set between writes.

The exact resulting values can only be shown by the bench's scenarios. These include the wrap at the top of the address space, the count running out, the fixed-address mode, a write colliding with a done pulse, and the registers keeping their contents across reset.

// File: rtl/dstp_pkg.sv
package dstp_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_WORD  = 2'b01,
      SZ_LONG  = 2'b10,
      SZ_LONG2 = 2'b11
   } opsz_e;

   localparam int STEP_W = 3;

   function automatic logic [STEP_W-1:0] size_step(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_step = 3'd1;
         SZ_WORD: size_step = 3'd2;
         default: size_step = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dstp_step_dec.sv
module dstp_step_dec
   import dstp_pkg::*;
(
   input  logic [1:0]        op_size,
   input  logic              addr_lsb,
   output logic [STEP_W-1:0] step,
   output logic              misaligned
);

   always_comb begin
      step       = size_step(op_size);
      misaligned = (op_size != SZ_BYTE) && addr_lsb;
   end

endmodule

// File: rtl/dstp_addr_reg.sv
module dstp_addr_reg
   import dstp_pkg::*;
#(
   parameter int W = 32
) (
   input  logic              clk,
   input  logic              ld,
   input  logic [W-1:0]      ld_val,
   input  logic              adv,
   input  logic [STEP_W-1:0] step,
   output logic [W-1:0]      q
);

   localparam int PAD = W - STEP_W;

   logic [W-1:0] step_ext;
   assign step_ext = {{PAD{1'b0}}, step};

   // No reset on purpose: contents survive a reset pulse.
   always_ff @(posedge clk) begin
      if (ld) begin
         q <= ld_val;
      end else if (adv) begin
         q <= q + step_ext;   // unsigned, wraps modulo 2**W
      end
   end

endmodule

// File: rtl/dstp_cnt_reg.sv
module dstp_cnt_reg
   import dstp_pkg::*;
#(
   parameter int W = 32
) (
   input  logic              clk,
   input  logic              ld,
   input  logic [W-1:0]      ld_val,
   input  logic              dec,
   input  logic [STEP_W-1:0] step,
   output logic [W-1:0]      q,
   output logic              is_zero,
   output logic              too_short
);

   localparam int PAD = W - STEP_W;

   logic [W-1:0] step_ext;
   assign step_ext = {{PAD{1'b0}}, step};

   always_ff @(posedge clk) begin
      if (ld) begin
         q <= ld_val;
      end else if (dec) begin
         q <= q - step_ext;
      end
   end

   always_comb begin
      is_zero   = (q == '0);
      too_short = (q < step_ext);
   end

endmodule

// File: rtl/dstp_flags.sv
module dstp_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set_cfg,
   input  logic set_berr,
   output logic cfg_err,
   output logic berr_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_err   <= 1'b0;
         berr_flag <= 1'b0;
      end else if (clr) begin
         cfg_err   <= 1'b0;
         berr_flag <= 1'b0;
      end else begin
         if (set_cfg)  cfg_err   <= 1'b1;
         if (set_berr) berr_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/dma_dst_path.sv
module dma_dst_path
   import dstp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_count,
   input  logic [31:0]       wdata,
   input  logic              inc_en,
   input  logic [1:0]        op_size,
   input  logic              stop,
   input  logic              done,
   input  logic              bus_err,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic              cfg_err,
   output logic              xfer_ok,
   output logic              blk_done,
   output logic              berr_flag
);

   localparam int MIN_W = 8;

   generate
      if (ADDR_W < MIN_W || ADDR_W > 32) begin : g_bad_aw
         $error("dma_dst_path: ADDR_W must be within 8..32");
      end
      if (CNT_W < MIN_W || CNT_W > 32) begin : g_bad_cw
         $error("dma_dst_path: CNT_W must be within 8..32");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic              misaligned;
   logic              ld_a, ld_c, any_wr;
   logic              accept, adv_a;
   logic              cnt_zero, cnt_short;

   // Register writes are accepted only while the module runs.
   assign ld_a   = wr_addr  && !stop;
   assign ld_c   = wr_count && !stop;
   assign any_wr = ld_a || ld_c;

   dstp_step_dec u_dec (
      .op_size    (op_size),
      .addr_lsb   (dst_addr[0]),
      .step       (step),
      .misaligned (misaligned)
   );

   // Permit: running, aligned, no pending error, enough bytes left.
   assign xfer_ok = !stop && !misaligned && !cfg_err && !berr_flag &&
                    !cnt_zero && !cnt_short;

   // A write in the same cycle wins over the hardware update.
   assign accept = rst_n && done && xfer_ok && !bus_err && !any_wr;
   assign adv_a  = accept && inc_en;

   dstp_addr_reg #(.W(ADDR_W)) u_areg (
      .clk    (clk),
      .ld     (ld_a),
      .ld_val (wdata[ADDR_W-1:0]),
      .adv    (adv_a),
      .step   (step),
      .q      (dst_addr)
   );

   dstp_cnt_reg #(.W(CNT_W)) u_creg (
      .clk       (clk),
      .ld        (ld_c),
      .ld_val    (wdata[CNT_W-1:0]),
      .dec       (accept),
      .step      (step),
      .q         (byte_cnt),
      .is_zero   (cnt_zero),
      .too_short (cnt_short)
   );

   dstp_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (any_wr),
      .set_cfg   (misaligned && !stop),
      .set_berr  (bus_err && !stop),
      .cfg_err   (cfg_err),
      .berr_flag (berr_flag)
   );

   assign blk_done = cnt_zero;

endmodule

// File: rtl/dstp_checker.sv
module dstp_checker
   import dstp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_addr,
   input logic              wr_count,
   input logic              inc_en,
   input logic [1:0]        op_size,
   input logic              stop,
   input logic              done,
   input logic              bus_err,
   input logic [ADDR_W-1:0] dst_addr,
   input logic [CNT_W-1:0]  byte_cnt,
   input logic              xfer_ok,
   input logic              blk_done,
   input logic              berr_flag
);

   logic [ADDR_W-1:0] chk_step;
   logic              clean_op;
   assign chk_step = ADDR_W'(size_step(op_size));
   assign clean_op = done && xfer_ok && !bus_err && !wr_addr && !wr_count;

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_op && inc_en) |=> dst_addr == $past(dst_addr) + $past(chk_step));

   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_op && !inc_en) |=> $stable(dst_addr));

   a_r5_misalign_block: assert property (@(posedge clk) disable iff (!rst_n)
      (op_size != 2'b00 && dst_addr[0]) |-> !xfer_ok);

   a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_cnt == '0) |-> (blk_done && !xfer_ok));

   a_r8_berr_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !stop && !wr_addr && !wr_count) |=>
         ($stable(dst_addr) && $stable(byte_cnt) && berr_flag));

   a_r8_berr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (berr_flag && !((wr_addr || wr_count) && !stop)) |=> berr_flag);

   a_r10_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> ($stable(dst_addr) && $stable(byte_cnt)));

   a_r10_stop_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
      stop |-> !xfer_ok);

endmodule

bind dma_dst_path dstp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_addr   (wr_addr),
   .wr_count  (wr_count),
   .inc_en    (inc_en),
   .op_size   (op_size),
   .stop      (stop),
   .done      (done),
   .bus_err   (bus_err),
   .dst_addr  (dst_addr),
   .byte_cnt  (byte_cnt),
   .xfer_ok   (xfer_ok),
   .blk_done  (blk_done),
   .berr_flag (berr_flag)
);

// File: tb/sim_dma_dst_path.sv
module sim_dma_dst_path;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 9;
   // {op_size[2], inc_en[1], addr[32], cnt[32], exp_addr[32], exp_cnt[32]}
   localparam logic [130:0] VEC [NV] = '{
      {2'b00, 1'b1, 32'h0000_1000, 32'd10, 32'h0000_1001, 32'd9},
      {2'b01, 1'b1, 32'h0000_2000, 32'd10, 32'h0000_2002, 32'd8},
      {2'b10, 1'b1, 32'h0000_3000, 32'd10, 32'h0000_3004, 32'd6},
      {2'b10, 1'b0, 32'h0000_4000, 32'd8,  32'h0000_4000, 32'd4},
      {2'b00, 1'b1, 32'hFFFF_FFFF, 32'd3,  32'h0000_0000, 32'd2},
      {2'b10, 1'b1, 32'hFFFF_FFFC, 32'd4,  32'h0000_0000, 32'd0},
      {2'b01, 1'b1, 32'h0000_5001, 32'd4,  32'h0000_5001, 32'd4},
      {2'b10, 1'b1, 32'h0000_6000, 32'd2,  32'h0000_6000, 32'd2},
      {2'b11, 1'b1, 32'h0000_7000, 32'd8,  32'h0000_7004, 32'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_addr = 1'b0, wr_count = 1'b0;
   logic [31:0] wdata = '0;
   logic        inc_en = 1'b0;
   logic [1:0]  op_size = 2'b00;
   logic        stop = 1'b0, done = 1'b0, bus_err = 1'b0;
   logic [31:0] dst_addr, byte_cnt;
   logic        cfg_err, xfer_ok, blk_done, berr_flag;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_dst_path u0 (
      .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_count(wr_count),
      .wdata(wdata), .inc_en(inc_en), .op_size(op_size), .stop(stop),
      .done(done), .bus_err(bus_err), .dst_addr(dst_addr),
      .byte_cnt(byte_cnt), .cfg_err(cfg_err), .xfer_ok(xfer_ok),
      .blk_done(blk_done), .berr_flag(berr_flag)
   );

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_a(input logic [31:0] v);
      @(negedge clk); wr_addr = 1'b1; wdata = v;
      @(negedge clk); wr_addr = 1'b0;
   endtask

   task automatic wr_c(input logic [31:0] v);
      @(negedge clk); wr_count = 1'b1; wdata = v;
      @(negedge clk); wr_count = 1'b0;
   endtask

   task automatic pulse_done(input logic with_err);
      @(negedge clk); done = 1'b1; bus_err = with_err;
      @(negedge clk); done = 1'b0; bus_err = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 cfg_err in reset", {31'd0, cfg_err}, 32'd0);
      chk("R11 berr_flag in reset", {31'd0, berr_flag}, 32'd0);
      rst_n = 1'b1;

      // R1 load and read back
      wr_a(32'hA5A5_0010);
      chk("R1 addr readback", dst_addr, 32'hA5A5_0010);
      wr_c(32'd100);
      chk("R1 count readback", byte_cnt, 32'd100);

      // Vector table: R2 R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_size = VEC[i][130:129];
         inc_en  = VEC[i][128];
         wr_a(VEC[i][127:96]);
         wr_c(VEC[i][95:64]);
         pulse_done(1'b0);
         chk($sformatf("R2/R3/R4/R5/R6 vec%0d addr", i), dst_addr, VEC[i][63:32]);
         chk($sformatf("R2/R3/R4/R5/R6 vec%0d cnt", i), byte_cnt, VEC[i][31:0]);
         if (i == 5) chk("R7 blk_done at zero", {31'd0, blk_done}, 32'd1);
         if (i == 5) chk("R7 no permit at zero", {31'd0, xfer_ok}, 32'd0);
         if (i == 6) chk("R5 cfg_err set", {31'd0, cfg_err}, 32'd1);
         if (i == 6) chk("R5 no permit misaligned", {31'd0, xfer_ok}, 32'd0);
         if (i == 7) chk("R6 no permit short", {31'd0, xfer_ok}, 32'd0);
      end

      // R9 write clears cfg_err
      op_size = 2'b01;
      wr_a(32'h0000_5000);
      wr_a(32'h0000_5001);
      @(negedge clk);
      chk("R5 cfg_err after misaligned write", {31'd0, cfg_err}, 32'd1);
      wr_a(32'h0000_5000);
      chk("R9 write clears cfg_err", {31'd0, cfg_err}, 32'd0);

      // R8 bus error freezes and is sticky
      op_size = 2'b10; inc_en = 1'b1;
      wr_a(32'h0000_8000);
      wr_c(32'd16);
      pulse_done(1'b1);
      chk("R8 addr held", dst_addr, 32'h0000_8000);
      chk("R8 cnt held", byte_cnt, 32'd16);
      chk("R8 flag set", {31'd0, berr_flag}, 32'd1);
      chk("R8 no permit", {31'd0, xfer_ok}, 32'd0);
      pulse_done(1'b0);
      chk("R8 done ignored after error", dst_addr, 32'h0000_8000);
      chk("R8 flag sticky", {31'd0, berr_flag}, 32'd1);
      wr_c(32'd16);
      chk("R9 write clears berr_flag", {31'd0, berr_flag}, 32'd0);

      // R9 write wins over done in same cycle
      @(negedge clk); done = 1'b1; wr_addr = 1'b1; wdata = 32'h0000_9000;
      @(negedge clk); done = 1'b0; wr_addr = 1'b0;
      chk("R9 addr from write", dst_addr, 32'h0000_9000);
      chk("R9 cnt not stepped", byte_cnt, 32'd16);

      // R10 stop freezes
      @(negedge clk); stop = 1'b1;
      #1 chk("R10 no permit when stopped", {31'd0, xfer_ok}, 32'd0);
      wr_a(32'h0000_ABCD);
      chk("R10 write ignored", dst_addr, 32'h0000_9000);
      pulse_done(1'b0);
      chk("R10 done ignored cnt", byte_cnt, 32'd16);
      pulse_done(1'b1);
      chk("R10 bus_err ignored", {31'd0, berr_flag}, 32'd0);
      @(negedge clk); stop = 1'b0;

      // R11 registers survive reset, flags clear
      op_size = 2'b01;
      wr_a(32'h0000_9001);
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R11 cfg_err cleared", {31'd0, cfg_err}, 32'd0);
      chk("R11 berr cleared", {31'd0, berr_flag}, 32'd0);
      chk("R11 addr kept", dst_addr, 32'h0000_9001);
      chk("R11 cnt kept", byte_cnt, 32'd16);
      rst_n = 1'b1;
      op_size = 2'b00;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule